// File: doc/BRIEF.md
# Iterative Shift Multiply Divide Engine

This block is a sequential arithmetic unit for a processor datapath. A pair of word registers, the upper word and the lower word, carry one double-width operand or result and have their own shift network. A second-operand register keeps the multiplier or divisor for the whole operation, and a loop counter tracks how many shift steps have been done. One shared datapath serves three operations: unsigned multiply of two words, unsigned division of a double word by a word (quotient and remainder), and normalize, which shifts a double word left until its top bit is set and reports how many places it moved.

The caller presents an opcode and operands with a one-cycle start strobe while the unit is idle. The unit raises busy, iterates one step per clock, and then pulses done for one cycle with busy low. Results, the shift count and the flags stay on the outputs until the next accepted start. Subtraction inside the divide loop is formed by inverting the stored divisor and feeding a carry-in of one into the adder, so one adder serves both the add steps of multiply and the trial subtractions of divide.

Top module: `shiftmd_engine`

## Requirements
- R1: With op code 2'b00, the result pair {res_hi, res_lo} equals opa_lo times opb as an unsigned 32-bit product; busy is high for exactly 16 cycles and done follows.
- R2: With op code 2'b01 and opa_hi below opb, res_lo holds the quotient and res_hi the remainder of {opa_hi, opa_lo} divided by opb; busy is high for exactly 16 cycles.
- R3: With op code 2'b01 and opa_hi greater than or equal to opb (a zero divisor included), div_err is set, done pulses in the first cycle after the start edge without busy, and the result pair holds the dividend unchanged.
- R4: With op code 2'b10 and a nonzero operand {opa_hi, opa_lo} that has k leading zeros, the result pair is the operand shifted left by k, shift_cnt equals k, and busy is high for k+1 cycles.
- R5: With op code 2'b10 and a zero operand, zero_flag is set, done pulses in the first cycle after the start edge without busy, and the result pair and shift_cnt are zero.
- R6: Busy rises only in the cycle after an accepted start; done is a single-cycle pulse during which busy is low.
- R7: A start strobe while busy is ignored: the running operation completes with its own result and no extra done pulse follows.
- R8: Op code 2'b11 is reserved; a start with it is not accepted, busy and done stay low and the outputs keep their values.
- R9: After reset busy, done, both result words, shift_cnt, div_err and zero_flag are all zero.
- R10: After a completed multiply or divide, shift_cnt reads 16, the number of loop steps taken.
- R11: div_err and zero_flag are cleared by the next accepted start that does not raise them again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | Operation select: 00 multiply, 01 divide, 10 normalize, 11 reserved |
| opa_hi | input | 16 | Upper word of the double-width operand (dividend or normalize input) |
| opa_lo | input | 16 | Lower word of the double-width operand; multiplicand for multiply |
| opb | input | 16 | Multiplier or divisor |
| busy | output | 1 | High while iterating |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 16 | Upper result word: product high, remainder, or normalized high |
| res_lo | output | 16 | Lower result word: product low, quotient, or normalized low |
| shift_cnt | output | 6 | Loop counter value at completion |
| div_err | output | 1 | Divide could not run: divisor zero or quotient would not fit |
| zero_flag | output | 1 | Normalize input was zero |

## Verification
The bench builds the engine with its default word width of 16, so the loop counter is six bits wide and a normalize of the value one needs the full 31 shift steps plus the check cycle. At that width the corners are within direct reach: the largest product of two all-ones words, a divide whose upper dividend word is one below the divisor, divisors of zero and one, and normalize inputs with the top bit already set or only bit zero set. Random operands from a fixed seed then cover the three operations in mixed order, with the divide dividend drawn so most cases are legal and some overflow, and the measured latency is compared with the step count each requirement predicts.

// File: rtl/mds_pkg.sv
package mds_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_DIV  = 2'b01,
        OP_NORM = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    typedef enum logic [2:0] {
        PAIR_HOLD = 3'd0,
        PAIR_LOAD = 3'd1,
        PAIR_MUL  = 3'd2,
        PAIR_DIV  = 3'd3,
        PAIR_SHL  = 3'd4
    } pair_cmd_e;

    typedef struct packed {
        pair_cmd_e cmd;
        logic      cnt_clr;
        logic      cnt_inc;
        logic      sub;
        logic      use_shl;
        logic      opb_load;
    } ctl_t;

    function automatic logic op_accepted(input op_e o);
        return o != OP_RSVD;
    endfunction

    function automatic logic ends_at_start(input op_e o, input logic ovf, input logic zero);
        return ((o == OP_DIV) && ovf) || ((o == OP_NORM) && zero);
    endfunction

endpackage

// File: rtl/mds_addsub.sv
module mds_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = full[W-1:0];
        cout  = full[W];
    end
endmodule

// File: rtl/mds_loopcnt.sv
module mds_loopcnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (inc)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mds_wordpair.sv
module mds_wordpair
    import mds_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  pair_cmd_e     cmd,
    input  logic [W-1:0]  load_hi,
    input  logic [W-1:0]  load_lo,
    input  logic [W-1:0]  sum,
    input  logic          cout,
    output logic [W-1:0]  hi_q,
    output logic [W-1:0]  lo_q,
    output logic [W-1:0]  shl_hi
);
    logic [W-1:0] hi_d, lo_d;
    logic [W-1:0] mul_hi;
    logic         mul_carry;
    logic         div_take;

    always_comb begin
        shl_hi    = {hi_q[W-2:0], lo_q[W-1]};
        mul_hi    = lo_q[0] ? sum : hi_q;
        mul_carry = lo_q[0] & cout;
        div_take  = hi_q[W-1] | cout;
        hi_d      = hi_q;
        lo_d      = lo_q;
        case (cmd)
            PAIR_LOAD: begin
                hi_d = load_hi;
                lo_d = load_lo;
            end
            PAIR_MUL: begin
                hi_d = {mul_carry, mul_hi[W-1:1]};
                lo_d = {mul_hi[0], lo_q[W-1:1]};
            end
            PAIR_DIV: begin
                hi_d = div_take ? sum : shl_hi;
                lo_d = {lo_q[W-2:0], div_take};
            end
            PAIR_SHL: begin
                hi_d = shl_hi;
                lo_d = {lo_q[W-2:0], 1'b0};
            end
            default: begin
                hi_d = hi_q;
                lo_d = lo_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    // R4
    shl_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == PAIR_SHL) |=> (lo_q[0] == 1'b0));

    // R2
    div_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == PAIR_DIV && hi_q[W-1]) |=> (lo_q[0] == 1'b1));
endmodule

// File: rtl/mds_ctrl.sv
module mds_ctrl
    import mds_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  op_e           op_i,
    input  logic          div_ovf,
    input  logic          norm_zero,
    input  logic          hi_msb,
    input  logic [CW-1:0] cnt,
    output ctl_t          ctl,
    output op_e           cur_op,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          zero
);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);
    localparam logic [CW-1:0] NORM_MAX  = CW'(2 * W - 1);

    state_e state_q, state_d;
    op_e    op_q;
    logic   done_d;
    logic   accept;

    assign accept = start_i && (state_q == ST_IDLE) && op_accepted(op_i);
    assign busy   = (state_q == ST_RUN);
    assign cur_op = op_q;

    always_comb begin
        ctl     = '{cmd: PAIR_HOLD, cnt_clr: 1'b0, cnt_inc: 1'b0,
                    sub: 1'b0, use_shl: 1'b0, opb_load: 1'b0};
        state_d = state_q;
        done_d  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    ctl.cmd      = PAIR_LOAD;
                    ctl.cnt_clr  = 1'b1;
                    ctl.opb_load = 1'b1;
                    if (ends_at_start(op_i, div_ovf, norm_zero)) done_d = 1'b1;
                    else                                         state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                case (op_q)
                    OP_MUL: begin
                        ctl.cmd     = PAIR_MUL;
                        ctl.cnt_inc = 1'b1;
                        if (cnt == LAST_STEP) begin
                            state_d = ST_IDLE;
                            done_d  = 1'b1;
                        end
                    end
                    OP_DIV: begin
                        ctl.cmd     = PAIR_DIV;
                        ctl.cnt_inc = 1'b1;
                        ctl.sub     = 1'b1;
                        ctl.use_shl = 1'b1;
                        if (cnt == LAST_STEP) begin
                            state_d = ST_IDLE;
                            done_d  = 1'b1;
                        end
                    end
                    OP_NORM: begin
                        if (hi_msb || cnt == NORM_MAX) begin
                            state_d = ST_IDLE;
                            done_d  = 1'b1;
                        end else begin
                            ctl.cmd     = PAIR_SHL;
                            ctl.cnt_inc = 1'b1;
                        end
                    end
                    default: begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_MUL;
            done    <= 1'b0;
            err     <= 1'b0;
            zero    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= done_d;
            if (accept) begin
                op_q <= op_i;
                err  <= (op_i == OP_DIV) && div_ovf;
                zero <= (op_i == OP_NORM) && norm_zero;
            end
        end
    end

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_i));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i) |=> $stable(op_q));

    // R10
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && op_q != OP_NORM) |-> (cnt <= LAST_STEP));

    // R3
    err_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);
endmodule

// File: rtl/shiftmd_engine.sv
module shiftmd_engine
    import mds_pkg::*;
#(
    parameter  int WORD_W = 16,
    localparam int CNT_W  = $clog2(2 * WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [WORD_W-1:0] opa_hi,
    input  logic [WORD_W-1:0] opa_lo,
    input  logic [WORD_W-1:0] opb,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo,
    output logic [CNT_W-1:0]  shift_cnt,
    output logic              div_err,
    output logic              zero_flag
);
    ctl_t              ctl;
    op_e               cur_op;
    op_e               op_in;
    logic [WORD_W-1:0] opb_q;
    logic [WORD_W-1:0] hi_q, lo_q, shl_hi;
    logic [WORD_W-1:0] add_a, sum;
    logic [WORD_W-1:0] load_hi;
    logic              cout;
    logic              div_ovf, norm_zero;
    logic [CNT_W-1:0]  cnt;

    assign op_in     = op_e'(op);
    assign div_ovf   = (opa_hi >= opb);
    assign norm_zero = ({opa_hi, opa_lo} == '0);
    assign load_hi   = (op_in == OP_MUL) ? '0 : opa_hi;
    assign add_a     = ctl.use_shl ? shl_hi : hi_q;

    always_ff @(posedge clk) begin
        if (rst)               opb_q <= '0;
        else if (ctl.opb_load) opb_q <= opb;
    end

    mds_ctrl #(.W(WORD_W), .CW(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .op_i      (op_in),
        .div_ovf   (div_ovf),
        .norm_zero (norm_zero),
        .hi_msb    (hi_q[WORD_W-1]),
        .cnt       (cnt),
        .ctl       (ctl),
        .cur_op    (cur_op),
        .busy      (busy),
        .done      (done),
        .err       (div_err),
        .zero      (zero_flag)
    );

    mds_addsub #(.W(WORD_W)) u_addsub (
        .a    (add_a),
        .b    (opb_q),
        .sub  (ctl.sub),
        .sum  (sum),
        .cout (cout)
    );

    mds_wordpair #(.W(WORD_W)) u_pair (
        .clk     (clk),
        .rst     (rst),
        .cmd     (ctl.cmd),
        .load_hi (load_hi),
        .load_lo (opa_lo),
        .sum     (sum),
        .cout    (cout),
        .hi_q    (hi_q),
        .lo_q    (lo_q),
        .shl_hi  (shl_hi)
    );

    mds_loopcnt #(.CW(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (ctl.cnt_clr),
        .inc (ctl.cnt_inc),
        .cnt (cnt)
    );

    assign res_hi    = hi_q;
    assign res_lo    = lo_q;
    assign shift_cnt = cnt;

    // R2
    rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cur_op == OP_DIV && !div_err) |-> (res_hi < opb_q));

    // R4
    norm_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cur_op == OP_NORM && !zero_flag) |-> res_hi[WORD_W-1]);

    // R5
    zero_result_chk: assert property (@(posedge clk) disable iff (rst)
        (done && zero_flag) |-> (res_hi == '0 && res_lo == '0));
endmodule

// File: tb/sim_shiftmd_engine.sv
`timescale 1ns/1ps
module sim_shiftmd_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] opa_hi = '0, opa_lo = '0, opb = '0;
    logic        busy, done, div_err, zero_flag;
    logic [15:0] res_hi, res_lo;
    logic [5:0]  shift_cnt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    shiftmd_engine u0 (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .opa_hi(opa_hi), .opa_lo(opa_lo), .opb(opb),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
        .shift_cnt(shift_cnt), .div_err(div_err), .zero_flag(zero_flag)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lead_zeros(input logic [31:0] v);
        int n = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) return n;
            n++;
        end
        return 32;
    endfunction

    // Issue one operation, wait for done, return latency in cycles from the start edge.
    task automatic run_op(input logic [1:0] o, input logic [15:0] ah, input logic [15:0] al,
                          input logic [15:0] b, output int lat);
        @(negedge clk);
        start = 1'b1; op = o; opa_hi = ah; opa_lo = al; opb = b;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_op(input logic [1:0] o, input logic [15:0] ah, input logic [15:0] al,
                            input logic [15:0] b);
        int lat;
        logic [31:0] a32, res, exp;
        int k;
        a32 = {ah, al};
        run_op(o, ah, al, b, lat);
        res = {res_hi, res_lo};
        chk(done === 1'b1 && busy === 1'b0, "R6 done with busy low", {busy, done}, 2'b01);
        case (o)
            2'b00: begin
                exp = al * b;
                chk(res === exp, "R1 product", res, exp);
                chk(lat == 17, "R1 latency", lat, 17);
                chk(shift_cnt === 6'd16, "R10 count after multiply", shift_cnt, 16);
                chk(div_err === 1'b0 && zero_flag === 1'b0, "R11 flags clear", {div_err, zero_flag}, 0);
            end
            2'b01: begin
                if (ah >= b) begin
                    chk(div_err === 1'b1, "R3 error flag", div_err, 1);
                    chk(res === a32, "R3 dividend kept", res, a32);
                    chk(lat == 1, "R3 immediate done", lat, 1);
                end else begin
                    exp = {16'(a32 % b), 16'(a32 / b)};
                    chk(res === exp, "R2 remainder:quotient", res, exp);
                    chk(lat == 17, "R2 latency", lat, 17);
                    chk(shift_cnt === 6'd16, "R10 count after divide", shift_cnt, 16);
                    chk(div_err === 1'b0, "R11 error cleared", div_err, 0);
                end
            end
            default: begin
                if (a32 == 0) begin
                    chk(zero_flag === 1'b1, "R5 zero flag", zero_flag, 1);
                    chk(res === 32'd0 && shift_cnt === 6'd0, "R5 zero result", {shift_cnt, res}, 0);
                    chk(lat == 1, "R5 immediate done", lat, 1);
                end else begin
                    k = lead_zeros(a32);
                    exp = a32 << k;
                    chk(res === exp, "R4 normalized value", res, exp);
                    chk(shift_cnt == 6'(k), "R4 shift count", shift_cnt, k);
                    chk(lat == k + 2, "R4 latency", lat, k + 2);
                    chk(zero_flag === 1'b0, "R11 zero cleared", zero_flag, 0);
                end
            end
        endcase
        @(negedge clk);
        chk(done === 1'b0, "R6 single-cycle done", done, 0);
    endtask

    initial begin
        int lat;
        int seen;
        logic [31:0] keep;
        logic [15:0] b;
        logic [1:0]  o;
        void'($urandom(32'd1957));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(busy === 1'b0 && done === 1'b0, "R9 busy/done idle", {busy, done}, 0);
        chk({res_hi, res_lo} === 32'd0, "R9 result cleared", {res_hi, res_lo}, 0);
        chk(shift_cnt === 6'd0 && div_err === 1'b0 && zero_flag === 1'b0, "R9 count and flags",
            {shift_cnt, div_err, zero_flag}, 0);

        // Directed corners
        check_op(2'b00, 16'h0, 16'hFFFF, 16'hFFFF);
        check_op(2'b00, 16'h0, 16'h0000, 16'h1234);
        check_op(2'b00, 16'h0, 16'h8001, 16'h0001);
        check_op(2'b01, 16'h1233, 16'hFFFF, 16'h1234);
        check_op(2'b01, 16'h0000, 16'h0000, 16'h0001);
        check_op(2'b01, 16'h7FFF, 16'hFFFF, 16'hFFFF);
        check_op(2'b01, 16'h0000, 16'hFFFF, 16'h0001);
        check_op(2'b01, 16'h1234, 16'h5678, 16'h0000);
        check_op(2'b01, 16'h0005, 16'h0000, 16'h0005);
        check_op(2'b00, 16'h0, 16'h0003, 16'h0003);
        check_op(2'b10, 16'h0000, 16'h0000, 16'h0);
        check_op(2'b10, 16'h0000, 16'h0001, 16'h0);
        check_op(2'b10, 16'h8000, 16'h0000, 16'h0);
        check_op(2'b10, 16'h0001, 16'h0000, 16'h0);
        check_op(2'b10, 16'h0000, 16'h8000, 16'h0);

        // R7: start while busy is ignored
        @(negedge clk);
        start = 1'b1; op = 2'b00; opa_hi = 16'h0; opa_lo = 16'h00FF; opb = 16'h0101;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; op = 2'b01; opa_hi = 16'h0; opa_lo = 16'h0010; opb = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        lat = 5;
        while (!done && lat < 60) begin @(negedge clk); lat++; end
        chk({res_hi, res_lo} === 32'h0000FFFF, "R7 first result kept", {res_hi, res_lo}, 32'h0000FFFF);
        chk(div_err === 1'b0, "R7 no error from ignored start", div_err, 0);
        chk(lat == 17, "R7 latency unchanged", lat, 17);
        seen = 0;
        repeat (20) begin @(negedge clk); if (done || busy) seen++; end
        chk(seen == 0, "R7 no extra done", seen, 0);

        // R8: reserved opcode
        keep = {res_hi, res_lo};
        @(negedge clk);
        start = 1'b1; op = 2'b11; opa_hi = 16'hAAAA; opa_lo = 16'h5555; opb = 16'h0;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        repeat (20) begin if (done || busy) seen++; @(negedge clk); end
        chk(seen == 0, "R8 reserved op not accepted", seen, 0);
        chk({res_hi, res_lo} === keep, "R8 result unchanged", {res_hi, res_lo}, keep);

        // R11: error flag then a clean operation
        check_op(2'b01, 16'hFFFF, 16'h0000, 16'h0001);
        check_op(2'b00, 16'h0, 16'h0002, 16'h0003);

        // Random mix
        for (int i = 0; i < 240; i++) begin
            o = 2'($urandom % 3);
            case (o)
                2'b00: check_op(2'b00, 16'($urandom), 16'($urandom), 16'($urandom));
                2'b01: begin
                    b = 16'($urandom);
                    if (($urandom % 8) == 0 || b == 0)
                        check_op(2'b01, 16'($urandom), 16'($urandom), b);
                    else
                        check_op(2'b01, 16'($urandom % b), 16'($urandom), b);
                end
                default: begin
                    keep = 32'($urandom) >> ($urandom % 32);
                    check_op(2'b10, keep[31:16], keep[15:0], 16'($urandom));
                end
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule